// File: doc/BRIEF.md
# Processor Mode and Stack-Select Controller

This block holds the execution context of a small 32-bit core. It tracks three things: whether the core runs in Thread or Handler mode, whether Thread code is privileged, and which of two banked stack pointers (main or process) the stack-pointer register currently shows. The core drives single-cycle strobes into the block: an exception-entry strobe, an exception-return strobe with a return code, a control-register write and a stack-pointer write. The block answers with the current mode, the effective privilege, the selected stack and the value of the visible stack pointer. Instruction decode, exception priority and register stacking are handled outside this block.

A two-state machine carries the mode, with states ST_THREAD and ST_HANDLER. Every cycle resolves to one named transition. TR_ENTER moves from Thread to Handler. TR_NEST_ENTER raises the nesting depth while already in Handler. TR_RET_NEST lowers the depth and stays in Handler. TR_RET_THREAD drops to Thread once the last level unwinds. TR_RET_ILLEGAL flags a return that is refused. TR_CTRL_WRITE updates the control bits. TR_NONE holds the state. Control bit 0 (unprivileged Thread) and control bit 1 (process stack in Thread) live beside the state. A nesting counter records how many exception levels are open.

Top module: `msc_mode_stack`

## Requirements
- R1: After reset the block is in Thread mode and privileged, and it uses the main stack. The control value is 2'b00, and the visible stack pointer equals the main reset value 32'h2000_0400.
- R2: An entry strobe puts the block in Handler mode on the next cycle. In Handler mode the block is privileged and uses the main stack, whatever the control bits hold.
- R3: In privileged Thread mode, a control write stores data bit 0 as the unprivileged flag and data bit 1 as the process-stack select. In Thread mode the selected stack follows bit 1.
- R4: In unprivileged Thread mode, a control write is ignored completely. Thread code therefore cannot make itself privileged again.
- R5: In Handler mode, a control write updates bit 0 only and leaves bit 1 as it was. The Thread privilege that bit 0 sets takes effect after the return to Thread.
- R6: A stack-pointer write stores the data with bits 1:0 forced to zero, and only into the visible bank. The other bank keeps its value.
- R7: Return codes are decoded as follows. 4'h1 returns to a nested Handler level. 4'h9 returns to Thread on the main stack and clears bit 1. 4'hD returns to Thread on the process stack and sets bit 1.
- R8: The block returns to Thread mode only when the nesting depth falls from 1 to 0 and the code asks for Thread. A Handler-return code at depth 1 is refused, and so is a Thread-return code at depth 2 or more.
- R9: An unknown code, a refused return, or any return in Thread mode pulses illegal_ret_o for one cycle. Mode, depth and control stay unchanged.
- R10: When an entry strobe arrives in the same cycle as a return strobe or a control write, the entry wins and the other event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_entry_i | input | 1 | Exception-entry strobe |
| exc_return_i | input | 1 | Exception-return strobe |
| exc_ret_code_i | input | CODE_W | Return code that comes with the return strobe |
| ctrl_wr_i | input | 1 | Control-register write strobe |
| ctrl_wdata_i | input | 2 | Control write data: bit 0 unprivileged, bit 1 process stack |
| sp_wr_i | input | 1 | Stack-pointer write strobe |
| sp_wdata_i | input | SP_W | Stack-pointer write data |
| handler_mode_o | output | 1 | 1 in Handler mode |
| privileged_o | output | 1 | Effective privilege |
| proc_stack_o | output | 1 | 1 when the process stack is visible |
| ctrl_o | output | 2 | Stored control bits |
| sp_o | output | SP_W | Visible stack-pointer value |
| illegal_ret_o | output | 1 | One-cycle pulse for a refused return |

## Verification
On every cycle, the assertions check four things: an entry always lands in privileged Handler mode on the main stack; unprivileged Thread code never regains privilege without an entry; Thread mode only exists at zero depth; and a refused return leaves mode and depth untouched. They also check that the visible stack pointer stays word aligned and that a write to one bank leaves the other bank unchanged. Only the bench scenarios can show the rest. These cover the exact decoding of each return code, the mismatch between code and depth, the arbitration when events collide, the deferred effect of a Handler-mode privilege write, and which bank value appears after a round trip through Handler mode.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic {
        ST_THREAD  = 1'b0,
        ST_HANDLER = 1'b1
    } mode_state_e;

    typedef enum logic [1:0] {
        RK_NEST        = 2'd0,
        RK_THREAD_MAIN = 2'd1,
        RK_THREAD_PROC = 2'd2,
        RK_BAD         = 2'd3
    } ret_kind_e;

    typedef enum logic [2:0] {
        TR_NONE        = 3'd0,
        TR_ENTER       = 3'd1,
        TR_NEST_ENTER  = 3'd2,
        TR_RET_NEST    = 3'd3,
        TR_RET_THREAD  = 3'd4,
        TR_RET_ILLEGAL = 3'd5,
        TR_CTRL_WRITE  = 3'd6
    } mode_trans_e;

    localparam int CTRL_NPRIV_BIT = 0;
    localparam int CTRL_SPSEL_BIT = 1;

endpackage

// File: rtl/msc_ret_decode.sv
module msc_ret_decode
    import msc_pkg::*;
#(
    parameter int              CODE_W     = 4,
    parameter logic [CODE_W-1:0] CODE_NEST  = 4'h1,
    parameter logic [CODE_W-1:0] CODE_TMAIN = 4'h9,
    parameter logic [CODE_W-1:0] CODE_TPROC = 4'hD
) (
    input  logic [CODE_W-1:0] code_i,
    output ret_kind_e         kind_o
);

    always_comb begin
        if (code_i == CODE_NEST) begin
            kind_o = RK_NEST;
        end else if (code_i == CODE_TMAIN) begin
            kind_o = RK_THREAD_MAIN;
        end else if (code_i == CODE_TPROC) begin
            kind_o = RK_THREAD_PROC;
        end else begin
            kind_o = RK_BAD;
        end
    end

endmodule

// File: rtl/msc_mode_fsm.sv
module msc_mode_fsm
    import msc_pkg::*;
#(
    parameter int DEPTH_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        entry_i,
    input  logic        ret_i,
    input  ret_kind_e   ret_kind_i,
    input  logic        ctrl_wr_i,
    input  logic [1:0]  ctrl_wdata_i,
    output logic        handler_o,
    output logic        priv_o,
    output logic        proc_sel_o,
    output logic [1:0]  ctrl_o,
    output logic        illegal_o
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX  = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_ZERO = '0;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE  = DEPTH_W'(1);

    mode_state_e        state_q, state_d;
    logic [DEPTH_W-1:0] depth_q, depth_d;
    logic               npriv_q, npriv_d;
    logic               spsel_q, spsel_d;
    logic               illegal_q, illegal_d;
    mode_trans_e        trans;
    logic               ret_ok_nest;
    logic               ret_ok_thread;

    assign ret_ok_nest   = (ret_kind_i == RK_NEST) && (depth_q > DEPTH_ONE);
    assign ret_ok_thread = ((ret_kind_i == RK_THREAD_MAIN) || (ret_kind_i == RK_THREAD_PROC))
                           && (depth_q == DEPTH_ONE);

    // Transition selection: entry beats return, return beats control write.
    always_comb begin
        if (entry_i) begin
            trans = (state_q == ST_THREAD) ? TR_ENTER : TR_NEST_ENTER;
        end else if (ret_i) begin
            if (state_q == ST_HANDLER && ret_ok_nest) begin
                trans = TR_RET_NEST;
            end else if (state_q == ST_HANDLER && ret_ok_thread) begin
                trans = TR_RET_THREAD;
            end else begin
                trans = TR_RET_ILLEGAL;
            end
        end else if (ctrl_wr_i) begin
            trans = TR_CTRL_WRITE;
        end else begin
            trans = TR_NONE;
        end
    end

    always_comb begin
        state_d   = state_q;
        depth_d   = depth_q;
        npriv_d   = npriv_q;
        spsel_d   = spsel_q;
        illegal_d = 1'b0;
        unique case (trans)
            TR_ENTER: begin
                state_d = ST_HANDLER;
                depth_d = DEPTH_ONE;
            end
            TR_NEST_ENTER: begin
                depth_d = (depth_q == DEPTH_MAX) ? depth_q : depth_q + DEPTH_ONE;
            end
            TR_RET_NEST: begin
                depth_d = depth_q - DEPTH_ONE;
            end
            TR_RET_THREAD: begin
                state_d = ST_THREAD;
                depth_d = DEPTH_ZERO;
                spsel_d = (ret_kind_i == RK_THREAD_PROC);
            end
            TR_RET_ILLEGAL: begin
                illegal_d = 1'b1;
            end
            TR_CTRL_WRITE: begin
                if (state_q == ST_HANDLER) begin
                    npriv_d = ctrl_wdata_i[CTRL_NPRIV_BIT];
                end else if (!npriv_q) begin
                    npriv_d = ctrl_wdata_i[CTRL_NPRIV_BIT];
                    spsel_d = ctrl_wdata_i[CTRL_SPSEL_BIT];
                end
            end
            TR_NONE: begin
            end
            default: begin
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_THREAD;
            depth_q   <= DEPTH_ZERO;
            npriv_q   <= 1'b0;
            spsel_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            depth_q   <= depth_d;
            npriv_q   <= npriv_d;
            spsel_q   <= spsel_d;
            illegal_q <= illegal_d;
        end
    end

    // Outputs
    always_comb begin
        handler_o  = (state_q == ST_HANDLER);
        priv_o     = (state_q == ST_HANDLER) || !npriv_q;
        proc_sel_o = (state_q == ST_THREAD) && spsel_q;
        ctrl_o     = {spsel_q, npriv_q};
        illegal_o  = illegal_q;
    end

    AST_ENTRY_ENTERS_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> (state_q == ST_HANDLER)); // R2

    AST_UNPRIV_NO_SELF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THREAD && npriv_q && !entry_i) |=> npriv_q); // R4

    AST_THREAD_AT_ZERO_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THREAD) |-> (depth_q == DEPTH_ZERO)); // R8

    AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> (state_q == $past(state_q) && depth_q == $past(depth_q))); // R9

endmodule

// File: rtl/msc_sp_bank.sv
module msc_sp_bank #(
    parameter int            SP_W     = 32,
    parameter int            ALIGN_W  = 2,
    parameter logic [SP_W-1:0] MAIN_RST = 32'h2000_0400,
    parameter logic [SP_W-1:0] PROC_RST = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [SP_W-1:0] wdata_i,
    input  logic            sel_proc_i,
    output logic [SP_W-1:0] sp_o
);

    localparam int              NUM_BANKS  = 2;
    localparam logic [SP_W-1:0] ALIGN_MASK = ~((SP_W'(1) << ALIGN_W) - SP_W'(1));

    logic [SP_W-1:0] bank_q [NUM_BANKS];
    logic [SP_W-1:0] wdata_aligned;

    assign wdata_aligned = wdata_i & ALIGN_MASK;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [SP_W-1:0] RST_VAL = (b == 0) ? MAIN_RST : PROC_RST;
        logic hit;
        assign hit = wr_i && (sel_proc_i == (b == 1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[b] <= RST_VAL & ALIGN_MASK;
            end else if (hit) begin
                bank_q[b] <= wdata_aligned;
            end
        end
    end

    assign sp_o = sel_proc_i ? bank_q[1] : bank_q[0];

    AST_SP_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o[ALIGN_W-1:0] == '0); // R6

    AST_IDLE_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sel_proc_i) |=> $stable(bank_q[1])); // R6

endmodule

// File: rtl/msc_mode_stack.sv
module msc_mode_stack
    import msc_pkg::*;
#(
    parameter int              SP_W        = 32,
    parameter int              CODE_W      = 4,
    parameter int              DEPTH_W     = 4,
    parameter logic [SP_W-1:0] MAIN_SP_RST = 32'h2000_0400,
    parameter logic [SP_W-1:0] PROC_SP_RST = 32'h0000_0000,
    parameter logic [CODE_W-1:0] CODE_NEST  = 4'h1,
    parameter logic [CODE_W-1:0] CODE_TMAIN = 4'h9,
    parameter logic [CODE_W-1:0] CODE_TPROC = 4'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_entry_i,
    input  logic              exc_return_i,
    input  logic [CODE_W-1:0] exc_ret_code_i,
    input  logic              ctrl_wr_i,
    input  logic [1:0]        ctrl_wdata_i,
    input  logic              sp_wr_i,
    input  logic [SP_W-1:0]   sp_wdata_i,
    output logic              handler_mode_o,
    output logic              privileged_o,
    output logic              proc_stack_o,
    output logic [1:0]        ctrl_o,
    output logic [SP_W-1:0]   sp_o,
    output logic              illegal_ret_o
);

    ret_kind_e ret_kind;

    msc_ret_decode #(
        .CODE_W     (CODE_W),
        .CODE_NEST  (CODE_NEST),
        .CODE_TMAIN (CODE_TMAIN),
        .CODE_TPROC (CODE_TPROC)
    ) u_decode (
        .code_i (exc_ret_code_i),
        .kind_o (ret_kind)
    );

    msc_mode_fsm #(
        .DEPTH_W (DEPTH_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_i      (exc_entry_i),
        .ret_i        (exc_return_i),
        .ret_kind_i   (ret_kind),
        .ctrl_wr_i    (ctrl_wr_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .handler_o    (handler_mode_o),
        .priv_o       (privileged_o),
        .proc_sel_o   (proc_stack_o),
        .ctrl_o       (ctrl_o),
        .illegal_o    (illegal_ret_o)
    );

    msc_sp_bank #(
        .SP_W     (SP_W),
        .ALIGN_W  (2),
        .MAIN_RST (MAIN_SP_RST),
        .PROC_RST (PROC_SP_RST)
    ) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (sp_wr_i),
        .wdata_i    (sp_wdata_i),
        .sel_proc_i (proc_stack_o),
        .sp_o       (sp_o)
    );

    AST_ENTRY_PRIV_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry_i |=> (privileged_o && !proc_stack_o)); // R2

endmodule

// File: tb/tb_msc_mode_stack.sv
module tb_msc_mode_stack;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] MAIN_RST = 32'h2000_0400;

    typedef struct packed {
        logic [3:0] req;
        logic       ent;
        logic       ret;
        logic [3:0] code;
        logic       cwr;
        logic [1:0] cdat;
        logic       eh;
        logic       ep;
        logic       eproc;
        logic [1:0] ectrl;
        logic       eill;
    } row_t;

    localparam int NROWS = 17;
    // fields: req ent ret code cwr cdat | handler priv proc ctrl illegal
    localparam row_t TBL [NROWS] = '{
        '{4'd3,  1'b0,1'b0,4'h0,1'b1,2'b10, 1'b0,1'b1,1'b1,2'b10,1'b0}, // R3 select process stack
        '{4'd9,  1'b0,1'b1,4'h9,1'b0,2'b00, 1'b0,1'b1,1'b1,2'b10,1'b1}, // R9 return in Thread
        '{4'd2,  1'b1,1'b0,4'h0,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b10,1'b0}, // R2 entry
        '{4'd5,  1'b0,1'b0,4'h0,1'b1,2'b01, 1'b1,1'b1,1'b0,2'b11,1'b0}, // R5 bit1 kept
        '{4'd8,  1'b1,1'b0,4'h0,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b11,1'b0}, // R8 nest to 2
        '{4'd8,  1'b0,1'b1,4'h9,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b11,1'b1}, // R8 thread code at 2
        '{4'd7,  1'b0,1'b1,4'h1,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b11,1'b0}, // R7 nested return
        '{4'd8,  1'b0,1'b1,4'h1,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b11,1'b1}, // R8 handler code at 1
        '{4'd7,  1'b0,1'b1,4'h9,1'b0,2'b00, 1'b0,1'b0,1'b0,2'b01,1'b0}, // R7 thread main
        '{4'd4,  1'b0,1'b0,4'h0,1'b1,2'b10, 1'b0,1'b0,1'b0,2'b01,1'b0}, // R4 ignored
        '{4'd4,  1'b0,1'b0,4'h0,1'b1,2'b00, 1'b0,1'b0,1'b0,2'b01,1'b0}, // R4 no self raise
        '{4'd10, 1'b1,1'b1,4'hD,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b01,1'b0}, // R10 entry beats return
        '{4'd5,  1'b0,1'b0,4'h0,1'b1,2'b00, 1'b1,1'b1,1'b0,2'b00,1'b0}, // R5 restore privilege
        '{4'd7,  1'b0,1'b1,4'hD,1'b0,2'b00, 1'b0,1'b1,1'b1,2'b10,1'b0}, // R7 thread process
        '{4'd10, 1'b1,1'b0,4'h0,1'b1,2'b01, 1'b1,1'b1,1'b0,2'b10,1'b0}, // R10 entry beats write
        '{4'd9,  1'b0,1'b1,4'h5,1'b0,2'b00, 1'b1,1'b1,1'b0,2'b10,1'b1}, // R9 unknown code
        '{4'd7,  1'b0,1'b1,4'h9,1'b0,2'b00, 1'b0,1'b1,1'b0,2'b00,1'b0}  // R7 back to main
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_entry_i, exc_return_i, ctrl_wr_i, sp_wr_i;
    logic [3:0]  exc_ret_code_i;
    logic [1:0]  ctrl_wdata_i;
    logic [31:0] sp_wdata_i;
    logic        handler_mode_o, privileged_o, proc_stack_o, illegal_ret_o;
    logic [1:0]  ctrl_o;
    logic [31:0] sp_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msc_mode_stack dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .exc_entry_i    (exc_entry_i),
        .exc_return_i   (exc_return_i),
        .exc_ret_code_i (exc_ret_code_i),
        .ctrl_wr_i      (ctrl_wr_i),
        .ctrl_wdata_i   (ctrl_wdata_i),
        .sp_wr_i        (sp_wr_i),
        .sp_wdata_i     (sp_wdata_i),
        .handler_mode_o (handler_mode_o),
        .privileged_o   (privileged_o),
        .proc_stack_o   (proc_stack_o),
        .ctrl_o         (ctrl_o),
        .sp_o           (sp_o),
        .illegal_ret_o  (illegal_ret_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exc_entry_i    = 1'b0;
        exc_return_i   = 1'b0;
        exc_ret_code_i = 4'h0;
        ctrl_wr_i      = 1'b0;
        ctrl_wdata_i   = 2'b00;
        sp_wr_i        = 1'b0;
        sp_wdata_i     = 32'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " handler"}, {31'h0, handler_mode_o}, 32'h0);
        check({tag, " priv"},    {31'h0, privileged_o},   32'h1);
        check({tag, " proc"},    {31'h0, proc_stack_o},   32'h0);
        check({tag, " ctrl"},    {30'h0, ctrl_o},         32'h0);
        check({tag, " sp"},      sp_o,                    MAIN_RST);
        check({tag, " illegal"}, {31'h0, illegal_ret_o},  32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        do_reset();
        check_reset_state("R1 reset");

        // R6: stack writes align and land only in the visible bank
        sp_wr_i = 1'b1; sp_wdata_i = 32'h1234_5677;
        step();
        check("R6 main aligned", sp_o, 32'h1234_5674);
        ctrl_wr_i = 1'b1; ctrl_wdata_i = 2'b10;
        step();
        check("R6 process bank untouched", sp_o, 32'h0000_0000);
        sp_wr_i = 1'b1; sp_wdata_i = 32'hABCD_EF03;
        step();
        check("R6 process aligned", sp_o, 32'hABCD_EF00);
        exc_entry_i = 1'b1;
        step();
        check("R6 handler shows main", sp_o, 32'h1234_5674);
        exc_return_i = 1'b1; exc_ret_code_i = 4'hD;
        step();
        check("R6 process bank kept", sp_o, 32'hABCD_EF00);

        // Vector table from a fresh reset
        do_reset();
        for (int i = 0; i < NROWS; i++) begin
            exc_entry_i    = TBL[i].ent;
            exc_return_i   = TBL[i].ret;
            exc_ret_code_i = TBL[i].code;
            ctrl_wr_i      = TBL[i].cwr;
            ctrl_wdata_i   = TBL[i].cdat;
            step();
            check($sformatf("R%0d row%0d handler", TBL[i].req, i), {31'h0, handler_mode_o}, {31'h0, TBL[i].eh});
            check($sformatf("R%0d row%0d priv", TBL[i].req, i),    {31'h0, privileged_o},   {31'h0, TBL[i].ep});
            check($sformatf("R%0d row%0d proc", TBL[i].req, i),    {31'h0, proc_stack_o},   {31'h0, TBL[i].eproc});
            check($sformatf("R%0d row%0d ctrl", TBL[i].req, i),    {30'h0, ctrl_o},         {30'h0, TBL[i].ectrl});
            check($sformatf("R%0d row%0d illegal", TBL[i].req, i), {31'h0, illegal_ret_o},  {31'h0, TBL[i].eill});
        end

        // R9: illegal pulse lasts one cycle
        exc_return_i = 1'b1; exc_ret_code_i = 4'h1;
        step();
        check("R9 pulse set", {31'h0, illegal_ret_o}, 32'h1);
        step();
        check("R9 pulse cleared", {31'h0, illegal_ret_o}, 32'h0);

        // R1: reset from a busy state
        exc_entry_i = 1'b1;
        step();
        ctrl_wr_i = 1'b1; ctrl_wdata_i = 2'b01;
        step();
        do_reset();
        check_reset_state("R1 re-reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule